// File: doc/BRIEF.md
# Freezable Circular Capture Buffer

This block keeps a rolling record of the data words that cross a stream boundary, so that a host can read them back after an incident. While it records, every valid word is written into a circular RAM at the location held by a write pointer. The pointer then steps forward. When it passes the top location it returns to zero and raises a sticky wrap flag.

Recording can be halted in two ways. The first is a freeze bit carried on the end-of-event word. The second is a severe-error request raised beside the stream. In both cases the halt is deferred until the event in progress is complete. The end-of-event word is always stored before writing stops.

A controller with three states governs the block:

- SPY: records continuously.
- ARMED: still records, with a freeze owed at the next end-of-event word.
- FROZEN: holds the contents for readout.

The transitions are:

- SPY to FROZEN on a stored end-of-event word that carries the freeze bit, or that arrives together with an error request.
- SPY to ARMED on an error request without an end-of-event word.
- ARMED to FROZEN on the next stored end-of-event word.
- Any state to SPY on a host clear, which also zeroes the pointer and the wrap flag.
- Any state to SPY on an event-initialise pulse, which leaves the pointer, the flag and the contents alone.

The host reads the RAM through an address port with one cycle of latency. It can read the pointer, the flag and the state at any time.

Top module: `spy_capture_buffer`

## Requirements
- R1: After reset the pointer is 0, the wrap flag is 0 and the state output is SPY, encoded 0 (ARMED is 1, FROZEN is 2).
- R2: In SPY or ARMED, each cycle with `in_valid` high stores `in_data` at the current pointer, and the pointer then increases by one.
- R3: A store at location DEPTH-1 returns the pointer to 0 and sets the wrap flag. The flag stays set until a host clear or a reset.
- R4: A stored word with `in_eoe` and `in_freeze` both high is kept, and the state becomes FROZEN on the next cycle. `in_freeze` without `in_eoe` has no effect.
- R5: `err_freeze` in SPY without a stored end-of-event word moves the state to ARMED, and recording goes on. In ARMED the next stored end-of-event word is kept and the state becomes FROZEN. If `err_freeze` arrives together with a stored end-of-event word in SPY, the state goes straight to FROZEN.
- R6: In FROZEN no word is stored, the pointer and the flag stay unchanged, and `err_freeze` is ignored.
- R7: `host_clr` sets the pointer to 0, clears the wrap flag and selects SPY. It takes priority over every other input, and the word offered in that cycle is not stored.
- R8: `evt_init` selects SPY from any state and leaves the pointer, the flag and the stored words unchanged. The word offered in that cycle is not stored. `host_clr` wins when both are high.
- R9: `host_rd_en` with `host_addr` at a clock edge presents, after that edge, the word held at that address before any store in the same cycle. Reads work in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Data word strobe |
| in_data | input | DATA_W | Data word |
| in_eoe | input | 1 | Word ends the current event |
| in_freeze | input | 1 | Freeze bit of the end-of-event word |
| err_freeze | input | 1 | Severe-error freeze request |
| evt_init | input | 1 | Event-initialise pulse |
| host_clr | input | 1 | Host status write: clear pointer, flag, leave freeze |
| host_rd_en | input | 1 | Host RAM read strobe |
| host_addr | input | ADDR_W | Host RAM read address |
| host_rd_data | output | DATA_W | Host RAM read data, one cycle after the strobe |
| wr_ptr | output | ADDR_W | Current write pointer |
| wrap_flag | output | 1 | Sticky pointer-wrap flag |
| mode | output | 2 | Controller state: 0 SPY, 1 ARMED, 2 FROZEN |

## Verification
The hardest situation to reach is an error request that lands in the middle of an event. While it waits in ARMED, further stream words must still be stored. An end-of-event word must then close the event, and that word may arrive as the pointer wraps or in the same cycle as a host clear or an event-initialise pulse. Directed sequences place the error request before and on the end-of-event word. A reduced depth of 16 makes wraps frequent. Long seeded random runs mix rare error, clear and initialise pulses with dense traffic, so that these overlaps occur many times.

// File: rtl/spy_buf_pkg.sv
package spy_buf_pkg;
    typedef enum logic [1:0] {
        ST_SPY    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FROZEN = 2'd2
    } spy_state_e;
endpackage

// File: rtl/spy_freeze_ctrl.sv
module spy_freeze_ctrl
    import spy_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_eoe,
    input  logic       in_freeze,
    input  logic       err_freeze,
    input  logic       evt_init,
    input  logic       host_clr,
    output spy_state_e state,
    output logic       wr_en
);
    spy_state_e state_q, state_d;
    logic       eoe_word;

    assign eoe_word = in_valid && in_eoe;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SPY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (host_clr || evt_init) begin
            state_d = ST_SPY;
        end else begin
            unique case (state_q)
                ST_SPY: begin
                    if (eoe_word && (in_freeze || err_freeze)) state_d = ST_FROZEN;
                    else if (err_freeze)                      state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (eoe_word) state_d = ST_FROZEN;
                end
                ST_FROZEN: state_d = ST_FROZEN;
                default:   state_d = ST_SPY;
            endcase
        end
    end

    // outputs
    always_comb begin
        state = state_q;
        wr_en = 1'b0;
        unique case (state_q)
            ST_SPY, ST_ARMED: wr_en = in_valid && !host_clr && !evt_init;
            ST_FROZEN:        wr_en = 1'b0;
            default:          wr_en = 1'b0;
        endcase
    end

    // R6: frozen stays frozen unless clear or init
    p_frozen_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !host_clr && !evt_init) |=> (state_q == ST_FROZEN));
    // R5: armed moves only to frozen or spy
    p_armed_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && in_valid && in_eoe && !host_clr && !evt_init) |=> (state_q == ST_FROZEN));
    // R7 / R8: clear or init lands in spy
    p_clr_to_spy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr || evt_init) |=> (state_q == ST_SPY));
endmodule

// File: rtl/spy_wr_pointer.sv
module spy_wr_pointer #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              host_clr,
    output logic [ADDR_W-1:0] ptr,
    output logic              wrap
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            wrap <= 1'b0;
        end else if (host_clr) begin
            ptr  <= '0;
            wrap <= 1'b0;
        end else if (wr_en) begin
            if (ptr == LAST) begin
                ptr  <= '0;
                wrap <= 1'b1;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // R2: pointer steps by one per stored word
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !host_clr) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
    // R3: wrap flag is sticky
    p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !host_clr) |=> wrap);
    // R7: clear zeroes pointer and flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (ptr == '0 && !wrap));
    // R6: no store keeps the pointer still
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !host_clr) |=> $stable(ptr));
endmodule

// File: rtl/spy_ram.sv
module spy_ram #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/spy_capture_buffer.sv
module spy_capture_buffer
    import spy_buf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eoe,
    input  logic              in_freeze,
    input  logic              err_freeze,
    input  logic              evt_init,
    input  logic              host_clr,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              wrap_flag,
    output logic [1:0]        mode
);
    spy_state_e st;
    logic       wr_en;

    spy_freeze_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eoe(in_eoe),
        .in_freeze(in_freeze), .err_freeze(err_freeze), .evt_init(evt_init),
        .host_clr(host_clr), .state(st), .wr_en(wr_en)
    );

    spy_wr_pointer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .host_clr(host_clr),
        .ptr(wr_ptr), .wrap(wrap_flag)
    );

    spy_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(in_data),
        .re(host_rd_en), .raddr(host_addr), .rdata(host_rd_data)
    );

    assign mode = st;

    // R6: while frozen the pointer never moves unless cleared
    p_frozen_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !host_clr) |=> $stable(wr_ptr));
    // R8: init leaves the pointer and flag unchanged
    p_init_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_init && !host_clr) |=> ($stable(wr_ptr) && $stable(wrap_flag)));
endmodule

// File: tb/spy_capture_buffer_tb.sv
module spy_capture_buffer_tb;
    localparam int DW = 16;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_eoe = 0, in_freeze = 0, err_freeze = 0;
    logic evt_init = 0, host_clr = 0, host_rd_en = 0;
    logic [DW-1:0] in_data = '0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_rd_data;
    logic [AW-1:0] wr_ptr;
    logic wrap_flag;
    logic [1:0] mode;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] sh [D];
    bit            written [D];
    int m_ptr = 0, m_st = 0;
    bit m_wrap = 0;
    logic [DW-1:0] m_rd;
    bit m_rd_ok = 0;

    always #4 clk = ~clk;

    spy_capture_buffer #(.DATA_W(DW), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_eoe(in_eoe), .in_freeze(in_freeze), .err_freeze(err_freeze),
        .evt_init(evt_init), .host_clr(host_clr), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_rd_data(host_rd_data), .wr_ptr(wr_ptr),
        .wrap_flag(wrap_flag), .mode(mode)
    );

    function automatic int next_state(int st, bit v, bit e, bit f, bit er);
        if (st == 0) begin
            if (v && e && (f || er)) return 2;
            if (er) return 1;
            return 0;
        end
        if (st == 1) return (v && e) ? 2 : 1;
        return 2;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(bit v, logic [DW-1:0] d, bit e, bit f, bit er,
                       bit cl, bit in, bit re, logic [AW-1:0] a, string tag);
        in_valid = v; in_data = d; in_eoe = e; in_freeze = f; err_freeze = er;
        host_clr = cl; evt_init = in; host_rd_en = re; host_addr = a;
        @(posedge clk); #1;
        if (re) begin m_rd = sh[a]; m_rd_ok = written[a]; end
        if (cl) begin
            m_ptr = 0; m_wrap = 0; m_st = 0;
        end else if (in) begin
            m_st = 0;
        end else begin
            if (m_st != 2 && v) begin
                sh[m_ptr] = d; written[m_ptr] = 1;
                if (m_ptr == D-1) begin m_ptr = 0; m_wrap = 1; end
                else m_ptr++;
            end
            m_st = next_state(m_st, v, e, f, er);
        end
        chk({tag, " ptr"}, int'(wr_ptr), m_ptr);
        chk({tag, " wrap"}, int'(wrap_flag), int'(m_wrap));
        chk({tag, " mode"}, int'(mode), m_st);
        if (re && m_rd_ok) chk({tag, " R9 rdata"}, int'(host_rd_data), int'(m_rd));
        in_valid = 0; err_freeze = 0; host_clr = 0; evt_init = 0; host_rd_en = 0;
        in_eoe = 0; in_freeze = 0;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < D; i++) written[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset ptr", int'(wr_ptr), 0);
        chk("R1 reset wrap", int'(wrap_flag), 0);
        chk("R1 reset mode", int'(mode), 0);
        rst_n = 1;
        idle(1, "R1");
        // R2: simple stores
        for (int i = 0; i < 5; i++) cyc(1, DW'(16'h100 + i), 0, 0, 0, 0, 0, 0, '0, "R2");
        // R4: freeze bit without eoe ignored
        cyc(1, 16'h0AAA, 0, 1, 0, 0, 0, 0, '0, "R4 no-eoe");
        // R3: fill to wrap
        for (int i = 0; i < D; i++) cyc(1, DW'(16'h200 + i), 0, 0, 0, 0, 0, 0, '0, "R3");
        // R4: eoe with freeze bit
        cyc(1, 16'h0F0F, 1, 1, 0, 0, 0, 0, '0, "R4 eoe-freeze");
        // R6: frozen ignores words and errors
        cyc(1, 16'hDEAD, 1, 0, 1, 0, 0, 0, '0, "R6 frozen");
        cyc(1, 16'hBEEF, 0, 0, 0, 0, 0, 1, AW'(6), "R6 frozen read");
        for (int i = 0; i < D; i++) cyc(0, '0, 0, 0, 0, 0, 0, 1, AW'(i), "R9 readout");
        // R8: init leaves pointer, exits freeze
        cyc(1, 16'h1111, 0, 0, 0, 0, 1, 0, '0, "R8 init");
        // R7: clear with word
        cyc(1, 16'h2222, 0, 0, 0, 1, 1, 0, '0, "R7 clear");
        // R5: error mid-event then eoe
        cyc(1, 16'h3000, 0, 0, 1, 0, 0, 0, '0, "R5 arm");
        cyc(1, 16'h3001, 0, 0, 0, 0, 0, 0, '0, "R5 armed store");
        cyc(1, 16'h3002, 1, 0, 0, 0, 0, 0, '0, "R5 armed eoe");
        cyc(0, '0, 0, 0, 0, 0, 0, 1, AW'(2), "R5 read eoe");
        idle(1, "R9 latency");
        cyc(0, '0, 0, 0, 0, 1, 0, 0, '0, "R7 unfreeze");
        // R5: error with eoe same cycle
        cyc(1, 16'h4000, 1, 0, 1, 0, 0, 0, '0, "R5 same-cycle");
        cyc(0, '0, 0, 0, 0, 0, 1, 0, '0, "R8 init frozen");
        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit v  = ($urandom % 4) != 0;
            bit e  = ($urandom % 6) == 0;
            bit f  = ($urandom % 5) == 0;
            bit er = ($urandom % 40) == 0;
            bit cl = ($urandom % 90) == 0;
            bit in = ($urandom % 110) == 0;
            bit re = ($urandom % 2) == 0;
            cyc(v, DW'($urandom), e, f, er, cl, in, re, AW'($urandom), "R2-random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule